// File: doc/BRIEF.md
# Reset-Release Boot Mode Selector

This block decides, each time the chip's active-low reset line is released, whether the small processor core starts in ordinary user mode or in its built-in self-check mode. It watches three pins: the external reset line, a one-bit flag from an analog detector that reports an elevated test voltage on the interrupt pin, and a port pin that serves as a mode strap. All three pass through the same multi-flop synchroniser. Detection of the reset release opens a short sampling window.

The detector flag and the strap must both be high in every cycle of the window for self-check mode to be chosen. Any other combination, including a single-cycle dropout, selects user mode. The choice is latched and held until reset is asserted again. At the moment the mode is latched, the block raises a release signal that hands the strap and interrupt pins back to their ordinary functions.

The block also drives the first fetch address for the core. In self-check mode this is the fixed base of the self-check routine, 0x3F00. In user mode it is the normal reset vector supplied on an input.

Top module: `boot_mode_selector`

## Requirements
- R1: While the synchronised reset line is low, `self_check` is 0, `pins_released` is 0 and `start_addr` equals `user_vector`.
- R2: Self-check mode (`self_check` = 1) is selected only when `hv_detect` and `strap_pin` are both 1 at each of the two sampled clock edges, which are the edge at which `ext_reset_n` is first seen high and the edge that follows it.
- R3: If `hv_detect` is 0 during the window, the block enters user mode whatever the level of `strap_pin`.
- R4: If `strap_pin` is 0 during the window, the block enters user mode even when `hv_detect` is 1.
- R5: A dropout of either input in just one of the two sampled edges gives user mode.
- R6: In self-check mode `start_addr` is 0x3F00 and does not depend on `user_vector`. In user mode `start_addr` follows `user_vector`.
- R7: `pins_released` rises on the fourth rising clock edge after `ext_reset_n` goes high: two synchroniser edges and then two window edges. The latched mode is valid from that same edge.
- R8: Once the window has closed, changes on `hv_detect` and `strap_pin` have no effect on the mode.
- R9: When `ext_reset_n` goes low again, the mode returns to user and `pins_released` falls on the third rising edge. They keep their values through the two edges before it.
- R10: Synchronous `rst` high clears the block to the state of R1 within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| ext_reset_n | input | 1 | External active-low reset line (asynchronous) |
| hv_detect | input | 1 | Elevated-voltage flag from the interrupt pin detector |
| strap_pin | input | 1 | Port pin level used as the mode strap |
| user_vector | input | 16 | Normal reset vector used in user mode |
| self_check | output | 1 | 1 when self-check mode is latched |
| start_addr | output | 16 | First fetch address for the core |
| pins_released | output | 1 | 1 once strap and interrupt pins return to normal use |

## Verification
The bench aims at the narrow sampling window. It drops the detector flag or the strap in only the first or only the second sampled edge. A design that sampled once, or that ORed the samples, would then wrongly enter self-check. It also changes both inputs right after the window closes. A design whose latch stayed open would see its mode flip. It times the release edge and the clear after reset reassertion to the exact clock, so that a missing or extra synchroniser stage or window cycle shows up as an early or late transition. It also varies `user_vector` in both modes, which exposes a mux that picks the wrong source.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] SELF_CHECK_BASE = 16'h3F00;

    typedef enum logic {
        MODE_USER       = 1'b0,
        MODE_SELF_CHECK = 1'b1
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_HELD   = 2'd0,
        ST_WINDOW = 2'd1,
        ST_RUN    = 2'd2
    } sel_state_e;

    // bundle of raw pins carried through the synchroniser together
    typedef struct packed {
        logic rel_n;
        logic hv_flag;
        logic strap;
    } pin_sample_t;

    localparam int PIN_W = $bits(pin_sample_t);

    function automatic logic [ADDR_W-1:0] pick_vector(
        input op_mode_e          m,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] uv
    );
        return (m == MODE_SELF_CHECK) ? base : uv;
    endfunction

endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/boot_window_fsm.sv
module boot_window_fsm
    import boot_mode_pkg::*;
#(
    parameter int WINDOW_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rel_s,
    input  logic     hv_s,
    input  logic     strap_s,
    output op_mode_e mode,
    output logic     pins_free
);

    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    sel_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             acc;
    logic             sample;

    assign sample = hv_s & strap_s;

    always_ff @(posedge clk) begin
        if (rst || !rel_s) begin
            state     <= ST_HELD;
            cnt       <= '0;
            acc       <= 1'b0;
            mode      <= MODE_USER;
            pins_free <= 1'b0;
        end else begin
            case (state)
                ST_HELD: begin
                    acc   <= sample;
                    cnt   <= CNT_W'(1);
                    state <= ST_WINDOW;
                end
                ST_WINDOW: begin
                    if (cnt == LAST) begin
                        mode      <= op_mode_e'(acc & sample);
                        pins_free <= 1'b1;
                        state     <= ST_RUN;
                    end else begin
                        acc <= acc & sample;
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    state <= ST_RUN;
                end
            endcase
        end
    end

endmodule

// File: rtl/boot_vector_mux.sv
module boot_vector_mux
    import boot_mode_pkg::*;
#(
    parameter int                AW   = ADDR_W,
    parameter logic [AW-1:0]     BASE = SELF_CHECK_BASE
) (
    input  op_mode_e      mode,
    input  logic [AW-1:0] user_vec,
    output logic [AW-1:0] addr
);

    always_comb begin
        addr = pick_vector(mode, BASE, user_vec);
    end

endmodule

// File: rtl/boot_mode_selector.sv
module boot_mode_selector
    import boot_mode_pkg::*;
#(
    parameter int                  SYNC_STAGES   = 2,
    parameter int                  WINDOW_CYCLES = 2,
    parameter logic [ADDR_W-1:0]   CHECK_BASE    = SELF_CHECK_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_reset_n,
    input  logic              hv_detect,
    input  logic              strap_pin,
    input  logic [ADDR_W-1:0] user_vector,
    output logic              self_check,
    output logic [ADDR_W-1:0] start_addr,
    output logic              pins_released
);

    pin_sample_t raw_pins;
    pin_sample_t sync_pins;
    logic        rel_s;
    logic        hv_s;
    logic        strap_s;
    op_mode_e    mode;

    always_comb begin
        raw_pins.rel_n   = ext_reset_n;
        raw_pins.hv_flag = hv_detect;
        raw_pins.strap   = strap_pin;
    end

    boot_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    assign rel_s   = sync_pins.rel_n;
    assign hv_s    = sync_pins.hv_flag;
    assign strap_s = sync_pins.strap;

    boot_window_fsm #(
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rel_s     (rel_s),
        .hv_s      (hv_s),
        .strap_s   (strap_s),
        .mode      (mode),
        .pins_free (pins_released)
    );

    boot_vector_mux #(
        .AW   (ADDR_W),
        .BASE (CHECK_BASE)
    ) u_vec (
        .mode     (mode),
        .user_vec (user_vector),
        .addr     (start_addr)
    );

    assign self_check = (mode == MODE_SELF_CHECK);

endmodule

// File: rtl/boot_mode_selector_chk.sv
module boot_mode_selector_chk
    import boot_mode_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rel_s,
    input logic              hv_s,
    input logic              strap_s,
    input logic              self_check,
    input logic              pins_released,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] user_vector
);

    p_held_user_r1: assert property (@(posedge clk) disable iff (rst)
        !rel_s |=> (!self_check && !pins_released));

    p_both_high_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(self_check) |-> ($past(hv_s) && $past(strap_s) &&
                               $past(hv_s, 2) && $past(strap_s, 2)));

    p_check_addr_r6: assert property (@(posedge clk) disable iff (rst)
        self_check |-> (start_addr == SELF_CHECK_BASE));

    p_user_addr_r6: assert property (@(posedge clk) disable iff (rst)
        !self_check |-> (start_addr == user_vector));

    p_mode_with_release_r7: assert property (@(posedge clk) disable iff (rst)
        self_check |-> pins_released);

    p_release_after_window_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_released) |-> ($past(rel_s) && $past(rel_s, 2)));

    p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
        (pins_released && rel_s) |=> $stable(self_check));

    p_clear_r10: assert property (@(posedge clk)
        rst |=> (!self_check && !pins_released));

endmodule

bind boot_mode_selector boot_mode_selector_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rel_s         (rel_s),
    .hv_s          (hv_s),
    .strap_s       (strap_s),
    .self_check    (self_check),
    .pins_released (pins_released),
    .start_addr    (start_addr),
    .user_vector   (user_vector)
);

// File: tb/boot_mode_selector_test.sv
module boot_mode_selector_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [15:0] CHECK_BASE = 16'h3F00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_reset_n = 1'b0;
    logic        hv_detect = 1'b0;
    logic        strap_pin = 1'b0;
    logic [15:0] user_vector = 16'h1234;
    logic        self_check;
    logic [15:0] start_addr;
    logic        pins_released;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  sc;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];

    boot_mode_selector uut (
        .clk           (clk),
        .rst           (rst),
        .ext_reset_n   (ext_reset_n),
        .hv_detect     (hv_detect),
        .strap_pin     (strap_pin),
        .user_vector   (user_vector),
        .self_check    (self_check),
        .start_addr    (start_addr),
        .pins_released (pins_released)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: pops the expected mode when the release edge appears
    logic prev_rel = 1'b0;
    always @(negedge clk) begin
        if (pins_released && !prev_rel) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected release", 32'(pins_released), 32'd0);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                chk(self_check == e.sc, e.req, 32'(self_check), 32'(e.sc));
                chk(start_addr == (e.sc ? CHECK_BASE : user_vector), "R6 start address",
                    32'(start_addr), 32'(e.sc ? CHECK_BASE : user_vector));
            end
        end
        prev_rel = pins_released;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", 32'(cycles), 32'(WATCHDOG));
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // release reset with given levels at edges A and B, then verify and reassert
    task automatic run_boot(input logic hv_a, input logic st_a,
                            input logic hv_b, input logic st_b, input string req);
        exp_item_t e;
        logic sc;
        sc = hv_a & st_a & hv_b & st_b;
        e.sc = sc;
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        ext_reset_n = 1'b1; hv_detect = hv_a; strap_pin = st_a;
        @(posedge clk);                       // edge A
        @(negedge clk);
        hv_detect = hv_b; strap_pin = st_b;
        @(posedge clk);                       // edge B
        @(negedge clk);
        hv_detect = ~hv_b; strap_pin = ~st_b; // past the window
        @(posedge clk);                       // edge C
        @(negedge clk);
        chk(pins_released == 1'b0, "R7 not yet released after 3 edges",
            32'(pins_released), 32'd0);
        @(posedge clk);                       // edge D
        @(negedge clk);
        chk(pins_released == 1'b1, "R7 released on 4th edge", 32'(pins_released), 32'd1);
        // R8: wiggle inputs after the window
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hv_detect = i[0]; strap_pin = i[1];
            chk(self_check == sc, "R8 mode held after window", 32'(self_check), 32'(sc));
        end
        // R6: vector source follows mode
        user_vector = user_vector + 16'h0111;
        #1;
        chk(start_addr == (sc ? CHECK_BASE : user_vector), "R6 vector after change",
            32'(start_addr), 32'(sc ? CHECK_BASE : user_vector));
        // R9: reassert reset
        @(negedge clk);
        ext_reset_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(pins_released == 1'b1 && self_check == sc, "R9 held for two edges",
            32'({pins_released, self_check}), 32'({1'b1, sc}));
        @(posedge clk);
        @(negedge clk);
        chk(pins_released == 1'b0 && self_check == 1'b0, "R9 cleared on third edge",
            32'({pins_released, self_check}), 32'd0);
        chk(start_addr == user_vector, "R1 address while held",
            32'(start_addr), 32'(user_vector));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(self_check == 1'b0 && pins_released == 1'b0, "R10 state after rst",
            32'({self_check, pins_released}), 32'd0);
        chk(start_addr == user_vector, "R1 address after rst", 32'(start_addr),
            32'(user_vector));
        repeat (4) @(negedge clk);
        hv_detect = 1'b1; strap_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk(self_check == 1'b0 && pins_released == 1'b0, "R1 held with pins high",
            32'({self_check, pins_released}), 32'd0);

        run_boot(1'b1, 1'b1, 1'b1, 1'b1, "R2 both high selects self-check");
        run_boot(1'b0, 1'b1, 1'b0, 1'b1, "R3 flag low gives user");
        run_boot(1'b0, 1'b0, 1'b0, 1'b0, "R3 all low gives user");
        run_boot(1'b1, 1'b0, 1'b1, 1'b0, "R4 strap low gives user");
        run_boot(1'b1, 1'b1, 1'b0, 1'b1, "R5 flag drop second edge");
        run_boot(1'b0, 1'b1, 1'b1, 1'b1, "R5 flag drop first edge");
        run_boot(1'b1, 1'b1, 1'b1, 1'b0, "R5 strap drop second edge");
        run_boot(1'b1, 1'b0, 1'b1, 1'b1, "R5 strap drop first edge");
        run_boot(1'b1, 1'b1, 1'b1, 1'b1, "R2 self-check again");

        // R10: rst clears a latched self-check
        exp_q.push_back('{sc: 1'b1, req: "R2 before rst"});
        @(negedge clk);
        ext_reset_n = 1'b1; hv_detect = 1'b1; strap_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk(self_check == 1'b1, "R2 latched before rst", 32'(self_check), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(self_check == 1'b0 && pins_released == 1'b0, "R10 rst clears",
            32'({self_check, pins_released}), 32'd0);
        rst = 1'b0;
        ext_reset_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 every release seen", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule